// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a watchdog timer with a 32-bit word register interface. A 64-bit up-counter and a 64-bit compare period are each held as a low word and a high word. Software sets up the counting mode, releases both counter halves and loads a period while the watchdog is idle. It then arms the watchdog by writing two fixed 16-bit keys, one after the other, into the upper half of the watchdog control word.

Once the first arming key is accepted, the whole configuration is frozen. Only the key field of the watchdog control word still responds. While the watchdog is armed, software must repeat the two-key sequence before the counter reaches the period. A correct sequence clears the counter. If the counter is left to reach the period, the block latches a timeout flag and drives a reset request high for one clock. Only a system reset returns the block to the idle state.

Top module: `keyed_wdog`

## Requirements
- R1: After reset every readable word reads zero and `wdog_rst` is low.
- R2: While idle, writes take effect and read back at these word offsets: 0x10 and 0x14 (counter low and high), 0x18 and 0x1C (period low and high), 0x20 (run mode in bits 7:6), 0x24 (global word, bits 3:0). Global bit 0 releases the low counter half and bit 1 releases the high half; a half that is not released reads zero.
- R3: The counter advances by one per clock when the run mode is non-zero and both halves are released. A carry out of the low word increments the high word.
- R4: While not armed, a counter equal to the period holds there in run mode 1 and wraps to zero on the next clock in run mode 2.
- R5: Writing offset 0x28 with key 0xA5C6 in bits 31:16 and bit 14 set leaves the idle state. Bit 14 of 0x28 then reads 1. A following write of key 0xDA7E with bit 14 set arms the watchdog and clears the counter.
- R6: Once the idle state is left, writes to offsets 0x10 to 0x28 change nothing except the key handshake. The counter and period still read their live values. The key field always reads zero.
- R7: A key write that is not the expected next key makes the handshake wait for 0xA5C6 again, and it does not clear the counter.
- R8: While armed, writing 0xA5C6 and then 0xDA7E services the watchdog with or without bit 14 set. The counter reads zero on the clock that accepts the second key.
- R9: While armed, with global bits 3:2 equal to 2 and the counter running, a counter equal to the period sets the flag in bit 15 of 0x28 on the next clock. `wdog_rst` is high for exactly that one clock, and the counter then stops.
- R10: The timeout flag and the armed state hold until reset. A later service neither clears the flag nor produces a second pulse.
- R11: A service whose second key lands in the cycle where the counter equals the period wins. The counter clears and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdog_rst | output | 1 | One-clock reset request on timeout |

## Verification
The service clear and the timeout check can land on the same clock edge. This happens when the second service key is accepted in the cycle where the counter already equals the period. The bench sets up that collision by counting clocks exactly from a previous service: the first key lands as the counter steps onto the period and the second key lands one clock later. It then checks that the counter reads zero, that the flag is still clear and that no reset pulse appears. A later run without service must still time out, which shows the collision test sat on the right cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int unsigned OFS_CNT_LO = 32'h10;
  localparam int unsigned OFS_CNT_HI = 32'h14;
  localparam int unsigned OFS_PRD_LO = 32'h18;
  localparam int unsigned OFS_PRD_HI = 32'h1C;
  localparam int unsigned OFS_RUN    = 32'h20;
  localparam int unsigned OFS_GLOBAL = 32'h24;
  localparam int unsigned OFS_WDOG   = 32'h28;

  localparam int RUN_LSB    = 6;
  localparam int RUN_W      = 2;
  localparam int GLB_W      = 4;
  localparam int GLB_MODE_LSB = 2;
  localparam int EN_BIT     = 14;
  localparam int FLAG_BIT   = 15;

  localparam logic [RUN_W-1:0] RUN_OFF     = 2'd0;
  localparam logic [RUN_W-1:0] RUN_ONESHOT = 2'd1;
  localparam logic [RUN_W-1:0] RUN_CONT    = 2'd2;
  localparam logic [1:0]       GLB_WDOG    = 2'd2;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_PRE   = 2'd1,
    WD_ARMED = 2'd2
  } wd_state_e;

endpackage

// File: rtl/kwd_cfg_regs.sv
module kwd_cfg_regs
  import kwd_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PRD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prd_lo,
  input  logic              wr_prd_hi,
  input  logic              wr_run,
  input  logic              wr_glb,
  input  logic [DATA_W-1:0] wdata,
  output logic [PRD_W-1:0]  prd,
  output logic [RUN_W-1:0]  run_mode,
  output logic [GLB_W-1:0]  glb
);

  logic [DATA_W-1:0] prd_lo_q, prd_hi_q;
  logic [RUN_W-1:0]  run_q;
  logic [GLB_W-1:0]  glb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_lo_q <= '0;
    end else if (wr_prd_lo) begin
      prd_lo_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_hi_q <= '0;
    end else if (wr_prd_hi) begin
      prd_hi_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_OFF;
    end else if (wr_run) begin
      run_q <= wdata[RUN_LSB +: RUN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= '0;
    end else if (wr_glb) begin
      glb_q <= wdata[GLB_W-1:0];
    end
  end

  assign prd      = {prd_hi_q, prd_lo_q};
  assign run_mode = run_q;
  assign glb      = glb_q;

endmodule

// File: rtl/kwd_key_fsm.sv
module kwd_key_fsm
  import kwd_pkg::*;
#(
  parameter int               KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  output wd_state_e        state,
  output logic             kick
);

  wd_state_e st_q, st_d;
  logic      seen_q, seen_d;
  logic      second_ok;

  assign second_ok = (key == KEY_SECOND) && seen_q &&
                     (en_bit || (st_q == WD_ARMED));

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    kick   = 1'b0;
    if (key_wr) begin
      if (st_q == WD_IDLE) begin
        if ((key == KEY_FIRST) && en_bit) begin
          st_d   = WD_PRE;
          seen_d = 1'b1;
        end
      end else if (second_ok) begin
        st_d   = WD_ARMED;
        seen_d = 1'b0;
        kick   = 1'b1;
      end else begin
        seen_d = (key == KEY_FIRST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WD_IDLE;
      seen_q <= 1'b0;
    end else if (key_wr) begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/kwd_count_core.sv
module kwd_count_core
  import kwd_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  prd,
  input  logic [RUN_W-1:0]  run_mode,
  input  logic              rel_lo,
  input  logic              rel_hi,
  input  logic              wdog_mode,
  input  logic              armed,
  input  logic              kick,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag,
  output logic              pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, pulse_q;
  logic             run, hit, tmo, cnt_upd;

  assign run = (run_mode != RUN_OFF) && rel_lo && rel_hi && !flag_q;
  assign hit = (cnt_q == prd);
  assign tmo = armed && wdog_mode && run && hit && !kick;

  always_comb begin
    cnt_d = cnt_q;
    if (kick) begin
      cnt_d = '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[HALF_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:HALF_W] = wdata;
    end else if (run) begin
      if (!hit) begin
        cnt_d = cnt_q + 1'b1;
      end else if (!armed && (run_mode == RUN_CONT)) begin
        cnt_d = '0;
      end
    end
    if (!rel_lo) cnt_d[HALF_W-1:0]     = '0;
    if (!rel_hi) cnt_d[CNT_W-1:HALF_W] = '0;
  end

  assign cnt_upd = kick || wr_lo || wr_hi || run || !rel_lo || !rel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (tmo) begin
      flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tmo;
    end
  end

  assign cnt   = cnt_q;
  assign flag  = flag_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter int               KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rst
);

  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi;
  logic              sel_run, sel_glb, sel_wdog;
  logic              unlocked;
  logic [CNT_W-1:0]  prd, cnt;
  logic [RUN_W-1:0]  run_mode;
  logic [GLB_W-1:0]  glb;
  wd_state_e         state;
  logic              kick, flag, pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  assign sel_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
  assign sel_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
  assign sel_prd_lo = (bus_addr == ADDR_W'(OFS_PRD_LO));
  assign sel_prd_hi = (bus_addr == ADDR_W'(OFS_PRD_HI));
  assign sel_run    = (bus_addr == ADDR_W'(OFS_RUN));
  assign sel_glb    = (bus_addr == ADDR_W'(OFS_GLOBAL));
  assign sel_wdog   = (bus_addr == ADDR_W'(OFS_WDOG));

  assign unlocked = (state == WD_IDLE);

  kwd_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_prd_lo(bus_wr && unlocked && sel_prd_lo),
    .wr_prd_hi(bus_wr && unlocked && sel_prd_hi),
    .wr_run   (bus_wr && unlocked && sel_run),
    .wr_glb   (bus_wr && unlocked && sel_glb),
    .wdata    (bus_wdata),
    .prd      (prd),
    .run_mode (run_mode),
    .glb      (glb)
  );

  kwd_key_fsm #(
    .KEY_W     (KEY_W),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_keys (
    .clk   (clk),
    .rst_n (rst_n_s),
    .key_wr(bus_wr && sel_wdog),
    .key   (bus_wdata[DATA_W-1 -: KEY_W]),
    .en_bit(bus_wdata[EN_BIT]),
    .state (state),
    .kick  (kick)
  );

  kwd_count_core #(.HALF_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_lo    (bus_wr && unlocked && sel_cnt_lo),
    .wr_hi    (bus_wr && unlocked && sel_cnt_hi),
    .wdata    (bus_wdata),
    .prd      (prd),
    .run_mode (run_mode),
    .rel_lo   (glb[0]),
    .rel_hi   (glb[1]),
    .wdog_mode(glb[GLB_MODE_LSB +: 2] == GLB_WDOG),
    .armed    (state == WD_ARMED),
    .kick     (kick),
    .cnt      (cnt),
    .flag     (flag),
    .pulse    (pulse)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_cnt_lo) bus_rdata = cnt[DATA_W-1:0];
    if (sel_cnt_hi) bus_rdata = cnt[CNT_W-1:DATA_W];
    if (sel_prd_lo) bus_rdata = prd[DATA_W-1:0];
    if (sel_prd_hi) bus_rdata = prd[CNT_W-1:DATA_W];
    if (sel_run)    bus_rdata[RUN_LSB +: RUN_W] = run_mode;
    if (sel_glb)    bus_rdata[GLB_W-1:0] = glb;
    if (sel_wdog) begin
      bus_rdata[FLAG_BIT] = flag;
      bus_rdata[EN_BIT]   = !unlocked;
    end
  end

  assign wdog_rst = pulse;

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n_s,
  input wd_state_e        state,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic             kick,
  input logic             flag,
  input logic             pulse
);

  assert_lock_period_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state != WD_IDLE) |=> $stable(prd));

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    kick |=> (cnt == '0));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    pulse |=> !pulse);

  assert_pulse_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    pulse |-> flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    flag |=> flag);

  assert_armed_holds_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == WD_ARMED) |=> (state == WD_ARMED));

  assert_kick_beats_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    kick |=> !pulse);

endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n_s(rst_n_s),
  .state  (state),
  .cnt    (cnt),
  .prd    (prd),
  .kick   (kick),
  .flag   (flag),
  .pulse  (pulse)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;

  localparam int CLK_P = 10;
  localparam logic [15:0] K1 = 16'hA5C6;
  localparam logic [15:0] K2 = 16'hDA7E;
  localparam logic [31:0] EN = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst;

  int checks = 0;
  int fails = 0;
  int pulses = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    bit          nonzero;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  keyed_wdog uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .wdog_rst (wdog_rst)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (wdog_rst) pulses++;

  // monitor: pops the expected item and compares with the live read data
  always @(mon_ev) begin
    item_t it;
    #1;
    it = sb_q.pop_front();
    checks++;
    if (it.nonzero ? (bus_rdata == 32'h0) : (bus_rdata !== it.exp)) begin
      fails++;
      $display("FAIL %s: addr %h actual %h expected %s%h", it.tag, it.addr,
               bus_rdata, it.nonzero ? "nonzero, not " : "", it.exp);
    end
  end

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag,
                     input bit nz = 1'b0);
    item_t it;
    it.addr = a; it.exp = e; it.nonzero = nz; it.tag = tag;
    bus_addr = a;
    sb_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic chk_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk(8'h10, 0, "R1 cnt lo");
    chk(8'h18, 0, "R1 prd lo");
    chk(8'h24, 0, "R1 global");
    chk(8'h28, 0, "R1 wdog word");
    chk_val(int'(wdog_rst), 0, "R1 wdog_rst low");

    // R2 halves held while not released, then writable
    wr(8'h24, 32'h8);
    wr(8'h10, 32'h7);
    chk(8'h10, 0, "R2 low half held in reset");
    wr(8'h24, 32'hB);
    wr(8'h10, 32'h7);
    chk(8'h10, 32'h7, "R2 cnt lo write");
    wr(8'h1C, 32'h1234_5678);
    chk(8'h1C, 32'h1234_5678, "R2 prd hi write");
    chk(8'h24, 32'hB, "R2 global readback");

    // R3 counting: 10 idle cycles plus the stop edge
    wr(8'h1C, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 0);
    wr(8'h20, 32'h80);
    idle(10);
    wr(8'h20, 0);
    chk(8'h10, 32'd11, "R3 count 11");
    chk(8'h20, 0, "R2 run mode readback");

    // R3 carry into high word
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'h5);
    wr(8'h20, 32'h80);
    wr(8'h20, 0);
    chk(8'h10, 0, "R3 carry low");
    chk(8'h14, 32'h6, "R3 carry high");

    // R4 one-shot holds at period
    wr(8'h14, 0);
    wr(8'h10, 0);
    wr(8'h18, 32'd5);
    wr(8'h20, 32'h40);
    idle(20);
    wr(8'h20, 0);
    chk(8'h10, 32'd5, "R4 one-shot holds");

    // R4 continuous wraps: 1..5,0,1,2,3
    wr(8'h10, 0);
    wr(8'h20, 32'h80);
    idle(8);
    wr(8'h20, 0);
    chk(8'h10, 32'd3, "R4 continuous wrap");

    // arming setup: period 1000, continuous, watchdog mode
    wr(8'h18, 32'd1000);
    wr(8'h10, 0);
    wr(8'h20, 32'h80);
    wr(8'h28, {K1, 16'h0} | EN);
    chk(8'h28, EN, "R5 enable reads 1 after first key");

    // R6 configuration locked
    wr(8'h18, 32'd99);
    chk(8'h18, 32'd1000, "R6 period locked");
    wr(8'h20, 0);
    chk(8'h20, 32'h80, "R6 run mode locked");
    wr(8'h24, 0);
    chk(8'h24, 32'hB, "R6 global locked");
    wr(8'h28, 0);
    chk(8'h28, EN, "R6 wdog word locked");

    // R7 wrong key before second key: not armed, counter not cleared
    wr(8'h28, {16'h1234, 16'h0} | EN);
    wr(8'h28, {K2, 16'h0} | EN);
    chk(8'h10, 0, "R7 wrong key blocks arming", 1'b1);

    // R5 proper arming clears counter
    wr(8'h28, {K1, 16'h0} | EN);
    wr(8'h28, {K2, 16'h0} | EN);
    chk(8'h10, 0, "R5 arming clears counter");
    chk(8'h28, EN, "R5 armed, key field reads 0");

    // R8 service without enable bit
    idle(100);
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {K2, 16'h0});
    chk(8'h10, 0, "R8 service clears counter");

    // R7 wrong key while armed does not service
    idle(50);
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {16'hBEEF, 16'h0});
    wr(8'h28, {K2, 16'h0});
    chk(8'h10, 0, "R7 armed wrong key no clear", 1'b1);

    // R11 service lands in the cycle where counter equals period
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {K2, 16'h0});
    idle(999);
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {K2, 16'h0});
    chk(8'h10, 0, "R11 counter cleared on collision");
    chk(8'h28, EN, "R11 no flag on collision");
    chk_val(pulses, 0, "R11 no pulse on collision");

    // R9 timeout without service
    idle(1003);
    chk(8'h28, EN | 32'h8000, "R9 flag set");
    chk(8'h10, 32'd1000, "R9 counter stops at period");
    chk_val(pulses, 1, "R9 single pulse");

    // R10 flag sticky, no second pulse
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {K2, 16'h0});
    idle(1100);
    chk(8'h28, EN | 32'h8000, "R10 flag sticky");
    chk_val(pulses, 1, "R10 no second pulse");
    wr(8'h18, 32'd77);
    chk(8'h18, 32'd1000, "R10 still locked");

    // R10 only reset returns to idle
    do_reset();
    chk(8'h28, 0, "R10 reset clears state");
    wr(8'h18, 32'd77);
    chk(8'h18, 32'd77, "R10 writable after reset");

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule